// File: doc/BRIEF.md
# Serial 8N1 Character Transmitter

This block serialises one 8-bit character per request onto an asynchronous line. The format is one start bit (0), eight data bits sent least significant bit first, no parity, and one stop bit (1). The line idles high. A client waits for `ready` to be 1, places the character on `tx_data`, and raises `send` for at least one clock cycle. The block captures the character, drops `ready`, and sends the frame. It raises `ready` again when the stop bit ends.

The bit period is a whole number of clock cycles, `BIT_DIV = CLK_HZ / BAUD_HZ`, which is fixed at elaboration. With a 12 MHz clock the supported rates run from 300 to 115200 baud. Inside the block are a registered copy of the request, a character capture register, a 10-bit frame shift register, a bit-period tick generator, a bit counter, and a controller with three states:

- **IDLE** is the resting state, and `ready` is 1. When the registered request is seen, the controller captures the character and takes the transition IDLE→START.
- **START** lasts exactly one cycle. It loads the frame register, clears the bit counter and enables the tick generator, and it always takes the transition START→TRANS.
- **TRANS** shifts the frame out, one bit per tick. It takes the transition TRANS→IDLE when the bit counter reaches 11.

The frame register holds an extra idle 1 below the start bit. The line therefore stays high for one bit period after START before the start bit begins.

Top module: `ser8n1_tx`

## Requirements
- R1: While `rst_n` is 0 at a clock edge (the reset is synchronous), the block afterwards shows `txd` = 1 and `ready` = 1, including when a frame is in progress.
- R2: In IDLE `ready` is 1. When `send` is 1 at clock edge k, `ready` is 0 from edge k+1 onwards.
- R3: When `send` is first sampled at edge k, `txd` stays 1 until edge k+BIT_DIV+2, where it falls to the start bit 0.
- R4: Each frame is the start bit 0, then data bits 0 to 7 in that order (bit 0 first), then the stop bit 1. Every bit holds for exactly BIT_DIV clock cycles, and `txd` changes only at bit boundaries.
- R5: `ready` returns to 1 exactly 10*BIT_DIV cycles after the start bit begins, which is the end of the stop bit.
- R6: The character is captured when the request is accepted. Changes to `tx_data` after that do not alter the frame in flight.
- R7: A `send` pulse while `ready` is 0 is ignored. After the current frame ends, `txd` stays 1 and `ready` stays 1.
- R8: After a reset that aborts a frame, a new request produces a correct frame with the timing of R3 to R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| send | input | 1 | Transmit request, registered before use |
| tx_data | input | 8 | Character to transmit |
| txd | output | 1 | Registered serial line, idles high |
| ready | output | 1 | 1 when a new character can be requested |

## Verification
Several properties are checked on every cycle:
- Reset drives the line high and `ready` to 1.
- An accepted request drops `ready`.
- The line changes only two cycles after a bit tick.
- The bit counter never passes 11.
- The captured character stays frozen during TRANS.
- The line is high whenever `ready` has been 1 for two cycles.

Only the bench scenarios can show the rest:
- the exact start latency;
- the bit order and values of whole frames for several characters;
- the moment `ready` returns;
- that requests made while busy leave no trace;
- that a frame after a mid-frame reset is correct.

// File: rtl/ser8n1_pkg.sv
package ser8n1_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_TRANS = 2'd2
    } tx_state_t;
endpackage

// File: rtl/ser8n1_baud_tick.sv
module ser8n1_baud_tick #(
    parameter int BIT_DIV = 104
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (BIT_DIV > 2) ? $clog2(BIT_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(BIT_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = en && (cnt == LAST);
endmodule

// File: rtl/ser8n1_bit_count.sv
module ser8n1_bit_count #(
    parameter int END_COUNT = 11,
    localparam int CNT_W = $clog2(END_COUNT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             done
);
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            count <= '0;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end

    assign done = (count == CNT_W'(END_COUNT));
endmodule

// File: rtl/ser8n1_shifter.sv
module ser8n1_shifter #(
    parameter int DATA_W = 8,
    localparam int FRAME_W = DATA_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              capture,
    input  logic              load,
    input  logic              tick,
    output logic [DATA_W-1:0] held,
    output logic              line
);
    logic [FRAME_W-1:0] frame;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else if (capture) begin
            held <= din;
        end
    end

    // bit 0: idle 1, bit 1: start 0, upper bits: data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame <= '1;
        end else if (load) begin
            frame <= {held, 2'b01};
        end else if (tick) begin
            frame <= {1'b1, frame[FRAME_W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line <= 1'b1;
        end else begin
            line <= frame[0];
        end
    end
endmodule

// File: rtl/ser8n1_ctrl.sv
module ser8n1_ctrl
    import ser8n1_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic done,
    output logic capture,
    output logic load,
    output logic baud_en,
    output logic ready,
    output logic in_trans
);
    tx_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req)  state_nx = ST_START;
            ST_START:           state_nx = ST_TRANS;
            ST_TRANS: if (done) state_nx = ST_IDLE;
            default:            state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        capture  = 1'b0;
        load     = 1'b0;
        baud_en  = 1'b0;
        ready    = 1'b0;
        in_trans = 1'b0;
        unique case (state)
            ST_IDLE: begin
                ready   = 1'b1;
                capture = req;
            end
            ST_START: begin
                load    = 1'b1;
                baud_en = 1'b1;
            end
            ST_TRANS: begin
                baud_en  = 1'b1;
                in_trans = 1'b1;
            end
            default: ready = 1'b1;
        endcase
    end
endmodule

// File: rtl/ser8n1_tx.sv
module ser8n1_tx #(
    parameter int CLK_HZ  = 12_000_000,
    parameter int BAUD_HZ = 115_200,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send,
    input  logic [DATA_W-1:0] tx_data,
    output logic              txd,
    output logic              ready
);
    localparam int BIT_DIV   = CLK_HZ / BAUD_HZ;
    localparam int END_COUNT = DATA_W + 3;
    localparam int CNT_W     = $clog2(END_COUNT + 1);

    logic              send_q;
    logic              capture, load, baud_en, in_trans;
    logic              baud_tick, done;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] cap_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            send_q <= 1'b0;
        end else begin
            send_q <= send;
        end
    end

    ser8n1_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (send_q),
        .done     (done),
        .capture  (capture),
        .load     (load),
        .baud_en  (baud_en),
        .ready    (ready),
        .in_trans (in_trans)
    );

    ser8n1_baud_tick #(.BIT_DIV(BIT_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (baud_en),
        .tick  (baud_tick)
    );

    ser8n1_bit_count #(.END_COUNT(END_COUNT)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .tick  (baud_tick),
        .count (bit_cnt),
        .done  (done)
    );

    ser8n1_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (tx_data),
        .capture (capture),
        .load    (load),
        .tick    (baud_tick),
        .held    (cap_data),
        .line    (txd)
    );
endmodule

// File: rtl/ser8n1_tx_chk.sv
module ser8n1_tx_chk #(
    parameter int DATA_W    = 8,
    parameter int END_COUNT = 11,
    parameter int CNT_W     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              txd,
    input logic              ready,
    input logic              send_q,
    input logic              tick,
    input logic              in_trans,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic [DATA_W-1:0] cap_data
);
    // R1
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (txd && ready));

    // R2
    a_r2_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && send_q) |=> !ready);

    // R4
    a_r4_line_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) && $past(rst_n, 2) && !$stable(txd)) |-> $past(tick, 2));

    // R5
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(END_COUNT));

    // R6
    a_r6_data_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (in_trans && $past(rst_n)) |-> $stable(cap_data));

    // R7
    a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(ready) && $past(rst_n)) |-> txd);
endmodule

bind ser8n1_tx ser8n1_tx_chk #(
    .DATA_W    (DATA_W),
    .END_COUNT (END_COUNT),
    .CNT_W     (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .txd      (txd),
    .ready    (ready),
    .send_q   (send_q),
    .tick     (baud_tick),
    .in_trans (in_trans),
    .bit_cnt  (bit_cnt),
    .cap_data (cap_data)
);

// File: tb/tb_ser8n1_tx.sv
module tb_ser8n1_tx;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 12_000_000;
    localparam int BAUD_HZ    = 1_500_000;
    localparam int DIV        = CLK_HZ / BAUD_HZ;
    localparam int NVEC       = 6;
    localparam logic [7:0] VEC [NVEC] = '{8'h4B, 8'h00, 8'hFF, 8'hA5, 8'h01, 8'h80};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       send = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       txd, ready;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ser8n1_tx #(.CLK_HZ(CLK_HZ), .BAUD_HZ(BAUD_HZ)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .send    (send),
        .tx_data (tx_data),
        .txd     (txd),
        .ready   (ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_send(input logic [7:0] b);
        @(negedge clk);
        tx_data = b;
        send = 1'b1;
        @(negedge clk);
        send = 1'b0;
    endtask

    // send b and check the whole frame; scramble din after capture if asked
    task automatic frame_check(input logic [7:0] b, input bit scramble, input string tag);
        int k;
        logic [7:0] got;
        pulse_send(b);
        @(negedge clk);
        if (scramble) tx_data = ~b;
        chk(ready == 1'b0, {tag, " R2 ready low"}, ready, 0);
        k = 1;
        while (txd == 1'b1 && k < 4 * DIV) begin
            @(negedge clk);
            k++;
        end
        chk(k == DIV + 2, {tag, " R3 start latency"}, k, DIV + 2);
        repeat (DIV / 2) @(negedge clk);
        chk(txd == 1'b0, {tag, " R4 start bit"}, txd, 0);
        got = '0;
        for (int i = 0; i < 8; i++) begin
            repeat (DIV) @(negedge clk);
            got[i] = txd;
        end
        chk(got == b, {tag, " R4 R6 data bits"}, got, b);
        repeat (DIV) @(negedge clk);
        chk(txd == 1'b1, {tag, " R4 stop bit"}, txd, 1);
        repeat (DIV / 2 - 1) @(negedge clk);
        chk(ready == 1'b0, {tag, " R5 ready still low"}, ready, 0);
        @(negedge clk);
        chk(ready == 1'b1 && txd == 1'b1, {tag, " R5 ready back"}, ready, 1);
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        bit ok;
        repeat (3) @(negedge clk);
        chk(txd == 1'b1 && ready == 1'b1, "R1 reset state", {txd, ready}, 3);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            frame_check(VEC[v], 1'b0, $sformatf("vec%0d", v));
            repeat (3) @(negedge clk);
        end

        // R6: data input changed right after capture
        frame_check(8'h3C, 1'b1, "R6 scramble");

        // R7: request while busy
        pulse_send(8'hC3);
        repeat (4 * DIV) @(negedge clk);
        tx_data = 8'h55;
        send = 1'b1;
        @(negedge clk);
        send = 1'b0;
        while (!ready) @(negedge clk);
        ok = 1'b1;
        for (int c = 0; c < 3 * DIV; c++) begin
            @(negedge clk);
            if (!(txd && ready)) ok = 1'b0;
        end
        chk(ok, "R7 busy request ignored", ok, 1);

        // R1 / R8: reset mid-frame
        pulse_send(8'h96);
        repeat (3 * DIV) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1 && ready == 1'b1, "R1 mid-frame reset", {txd, ready}, 3);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        frame_check(8'h69, 1'b0, "R8 after reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule